// File: doc/BRIEF.md
# Burst-Gated Memory Read Engine

The engine takes read commands one at a time. Each command gives a start byte address, a length in words and a flag that says whether the address advances. For each command the engine reads that many words through a memory-mapped read master and places the returned words, in order, into an internal buffer. A downstream consumer drains that buffer through a valid/ready output. Addresses are taken to be word-aligned.

A read request goes out only when the buffer can take every word of that request. The engine counts the words already buffered and the words requested but not yet returned. With bursts enabled, the buffer holds twice the maximum burst length, so one burst can return while the previous one drains. Each burst asks for the maximum burst length, or for the words left in the command if fewer remain, so the final burst of a command may be short. A command with the advance flag clear reads the same address once per word, using single-word requests. With bursts disabled, every request is one word and the buffer holds two words.

Top module: `burst_rd_engine`

## Requirements
- R1: After reset, cmd_ready_o is 1, mem_read_o is 0 and out_valid_o is 0.
- R2: A command is taken only while cmd_ready_o is 1. cmd_ready_o stays 0 from the cycle after a command with nonzero length is taken until that command's last request has been accepted. mem_read_o is never 1 while cmd_ready_o is 1.
- R3: When cmd_incr_i is 1, each request's mem_burst_o is the smaller of MAX_BURST (4 by default) and the words left in the command. mem_burst_o is always between 1 and MAX_BURST.
- R4: When cmd_incr_i is 0, every request has mem_burst_o equal to 1 and mem_addr_o equal to the command address, and there is one request per word.
- R5: When cmd_incr_i is 1, the first request uses the command address, and each later request's address is the previous one plus 4 bytes times the previous burst length (32-bit words).
- R6: While mem_read_o is 1 and mem_wait_i is 1, mem_read_o, mem_addr_o and mem_burst_o hold their values into the next cycle.
- R7: A request is presented only if the words buffered, plus the words outstanding, plus its own burst length, total no more than the buffer depth (2*MAX_BURST). With out_ready_i held low, at most 2*MAX_BURST words are ever requested.
- R8: mem_rdata_i is captured only in cycles where mem_rvalid_i is 1. Captured words leave out_data_o unchanged and in arrival order, across back-to-back commands.
- R9: The buffer never holds more than 2*MAX_BURST words.
- R10: A command with length 0 is taken and produces no request, and cmd_ready_o stays 1.
- R11: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | A command is taken this cycle |
| cmd_addr_i | input | AW | Start byte address |
| cmd_len_i | input | LW | Length in words |
| cmd_incr_i | input | 1 | 1: the address advances; 0: fixed address |
| mem_read_o | output | 1 | Read request |
| mem_addr_o | output | AW | Request byte address |
| mem_burst_o | output | BCW | Words in this request |
| mem_wait_i | input | 1 | Slave stalls the request phase |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| out_valid_o | output | 1 | A buffered word is available |
| out_ready_i | input | 1 | The consumer takes the word |
| out_data_o | output | DW | Buffered word |

## Verification
The main function is tried with several input patterns. Incrementing commands whose lengths are and are not a multiple of the burst size show whether the burst length is clamped on the final burst and whether the address steps correctly. A fixed-address command shows whether the engine falls back to single-word requests. A long command with the consumer stalled shows whether the space check counts outstanding words, since the total words requested must stop exactly at the buffer depth. Back-to-back commands under random request stalls and random data gaps show whether request fields hold during a stall, and whether words stay in order where one command ends and the next begins.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} eng_state_e;
endpackage

// File: rtl/rd_fifo.sv
module rd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (do_pop) rd_q <= nxt(rd_q);
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/burst_issuer.sv
module burst_issuer
  import burst_rd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int BYTES = 4,
  parameter int EMB   = 4,
  parameter int DEPTH = 8,
  localparam int BCW  = $clog2(EMB) + 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = CW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [LW-1:0]  cmd_len_i,
  input  logic           cmd_incr_i,
  output logic           mem_read_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [BCW-1:0] mem_burst_o,
  input  logic           mem_wait_i,
  input  logic           mem_rvalid_i,
  input  logic [CW-1:0]  buf_cnt_i
);
  eng_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic          incr_q;
  logic [CW-1:0] outst_q;
  logic [BCW-1:0] blen;
  logic          room, fire, take;
  logic [SW-1:0] outst_nx;

  // burst length choice depends on whether bursts exist at all
  generate
    if (EMB == 1) begin : g_single
      assign blen = BCW'(1);
    end else begin : g_burst
      logic [LW-1:0] clamp;
      assign clamp = (rem_q < LW'(EMB)) ? rem_q : LW'(EMB);
      assign blen  = incr_q ? clamp[BCW-1:0] : BCW'(1);
    end
  endgenerate

  // space for the whole burst: buffered + in flight + this one
  assign room = (SW'(buf_cnt_i) + SW'(outst_q) + SW'(blen)) <= SW'(DEPTH);

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign mem_read_o  = (state_q == ST_RUN) && room;
  assign mem_addr_o  = addr_q;
  assign mem_burst_o = blen;
  assign fire        = mem_read_o && !mem_wait_i;
  assign take        = cmd_valid_i && cmd_ready_o && (cmd_len_i != '0);

  assign outst_nx = SW'(outst_q) + (fire ? SW'(blen) : '0) - (mem_rvalid_i ? SW'(1) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      incr_q  <= 1'b0;
      outst_q <= '0;
    end else begin
      outst_q <= outst_nx[CW-1:0];
      if (take) begin
        state_q <= ST_RUN;
        addr_q  <= cmd_addr_i;
        rem_q   <= cmd_len_i;
        incr_q  <= cmd_incr_i;
      end else if (fire) begin
        rem_q <= rem_q - LW'(blen);
        if (incr_q) addr_q <= addr_q + AW'(blen) * AW'(BYTES);
        if (rem_q == LW'(blen)) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LW        = 16,
  parameter int MAX_BURST = 4,
  parameter bit BURST_EN  = 1'b1,
  localparam int EMB      = BURST_EN ? MAX_BURST : 1,
  localparam int DEPTH    = 2 * EMB,
  localparam int BCW      = $clog2(EMB) + 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [LW-1:0]  cmd_len_i,
  input  logic           cmd_incr_i,
  output logic           mem_read_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [BCW-1:0] mem_burst_o,
  input  logic           mem_wait_i,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [DW-1:0]  out_data_o
);
  logic [CW-1:0] buf_cnt;
  logic          buf_empty;

  burst_issuer #(
    .AW(AW), .LW(LW), .BYTES(DW / 8), .EMB(EMB), .DEPTH(DEPTH)
  ) u_issuer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_len_i    (cmd_len_i),
    .cmd_incr_i   (cmd_incr_i),
    .mem_read_o   (mem_read_o),
    .mem_addr_o   (mem_addr_o),
    .mem_burst_o  (mem_burst_o),
    .mem_wait_i   (mem_wait_i),
    .mem_rvalid_i (mem_rvalid_i),
    .buf_cnt_i    (buf_cnt)
  );

  rd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mem_rvalid_i),
    .wdata_i (mem_rdata_i),
    .pop_i   (out_ready_i),
    .head_o  (out_data_o),
    .empty_o (buf_empty),
    .count_o (buf_cnt)
  );

  assign out_valid_o = !buf_empty;
endmodule

// File: rtl/burst_rd_chk.sv
module burst_rd_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BCW   = 3,
  parameter int DEPTH = 8,
  parameter int EMB   = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_ready_o,
  input logic           mem_read_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic [BCW-1:0] mem_burst_o,
  input logic           mem_wait_i,
  input logic           mem_rvalid_i,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [DW-1:0]  out_data_o
);
  // port-level model of words in flight and words held
  logic [15:0] fly_m, held_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fly_m  <= '0;
      held_m <= '0;
    end else begin
      fly_m  <= fly_m + ((mem_read_o && !mem_wait_i) ? 16'(mem_burst_o) : 16'd0)
                      - (mem_rvalid_i ? 16'd1 : 16'd0);
      held_m <= held_m + (mem_rvalid_i ? 16'd1 : 16'd0)
                       - ((out_valid_o && out_ready_i) ? 16'd1 : 16'd0);
    end
  end

  // R2
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_read_o);

  // R3
  burst_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_read_o |-> (mem_burst_o >= BCW'(1)) && (32'(mem_burst_o) <= EMB));

  // R6
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_read_o && mem_wait_i) |=> mem_read_o && $stable(mem_addr_o) && $stable(mem_burst_o));

  // R7
  space_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_read_o |-> (32'(fly_m) + 32'(held_m) + 32'(mem_burst_o)) <= DEPTH);

  // R8
  data_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> held_m != 16'd0);

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(held_m) <= DEPTH);

  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o));
endmodule

bind burst_rd_engine burst_rd_chk #(
  .AW(AW), .DW(DW), .BCW(BCW), .DEPTH(DEPTH), .EMB(EMB)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_ready_o  (cmd_ready_o),
  .mem_read_o   (mem_read_o),
  .mem_addr_o   (mem_addr_o),
  .mem_burst_o  (mem_burst_o),
  .mem_wait_i   (mem_wait_i),
  .mem_rvalid_i (mem_rvalid_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_data_o   (out_data_o)
);

// File: tb/burst_rd_engine_tb.sv
`timescale 1ns/1ps
module burst_rd_engine_tb;
  localparam int AW = 32, DW = 32, LW = 16, MB = 4, DEPTH = 2 * MB, BCW = $clog2(MB) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           cmd_valid = 1'b0, cmd_ready, cmd_incr = 1'b1;
  logic [AW-1:0]  cmd_addr = '0;
  logic [LW-1:0]  cmd_len = '0;
  logic           mem_read, mem_wait = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0]  mem_addr;
  logic [BCW-1:0] mem_burst;
  logic [DW-1:0]  mem_rdata = '0, out_data;
  logic           out_valid, out_ready = 1'b1;

  burst_rd_engine #(.AW(AW), .DW(DW), .LW(LW), .MAX_BURST(MB), .BURST_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr),
    .cmd_len_i(cmd_len), .cmd_incr_i(cmd_incr),
    .mem_read_o(mem_read), .mem_addr_o(mem_addr), .mem_burst_o(mem_burst),
    .mem_wait_i(mem_wait), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0, rand_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] req_a [$];
  int            req_b [$];
  logic [DW-1:0] got [$];
  logic [AW-1:0] beat_a [$];
  int            beat_t [$];

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a * 32'd7 + 32'h1234_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor at the edge: handshakes use pre-edge values
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_read && !mem_wait) begin
      req_a.push_back(mem_addr);
      req_b.push_back(int'(mem_burst));
      for (int i = 0; i < int'(mem_burst); i++) begin
        beat_a.push_back(mem_addr + AW'(4 * i));
        beat_t.push_back(cyc + 2);
      end
    end
    if (rst_n && out_valid && out_ready) got.push_back(out_data);
  end

  // responder and consumer drive on the falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wait <= stall_mode ? lfsr[3] : 1'b0;
    if (rand_ready) out_ready <= lfsr[7];
    if (beat_a.size() > 0 && beat_t[0] <= cyc && (!stall_mode || lfsr[5])) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_f(beat_a.pop_front());
      void'(beat_t.pop_front());
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic clear_logs();
    req_a.delete(); req_b.delete(); got.delete();
  endtask

  task automatic issue(input logic [AW-1:0] a, input int len, input bit inc);
    @(negedge clk);
    cmd_addr = a; cmd_len = LW'(len); cmd_incr = inc; cmd_valid = 1'b1;
    do @(posedge clk); while (!cmd_ready);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 4000 && got.size() < n; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // compare requests and data against a model of one or more commands
  task automatic expect_cmd(input logic [AW-1:0] a, input int len, input bit inc,
                            inout int ri, inout int di, input string tag);
    int rem = len;
    logic [AW-1:0] p = a;
    while (rem > 0) begin
      int b = inc ? ((rem < MB) ? rem : MB) : 1;
      chk(ri < req_a.size() && req_a[ri] == p, {tag, " addr (R5/R4)"},
          (ri < req_a.size()) ? longint'(req_a[ri]) : -1, longint'(p));
      chk(ri < req_b.size() && req_b[ri] == b, {tag, " burst (R3/R4)"},
          (ri < req_b.size()) ? req_b[ri] : -1, b);
      ri++; rem -= b;
      if (inc) p += AW'(4 * b);
    end
    for (int k = 0; k < len; k++) begin
      logic [AW-1:0] wa = inc ? a + AW'(4 * k) : a;
      chk(di < got.size() && got[di] == mem_f(wa), {tag, " data (R8)"},
          (di < got.size()) ? longint'(got[di]) : -1, longint'(mem_f(wa)));
      di++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(mem_read == 1'b0, "R1 mem_read", mem_read, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic t_incr();
    int ri = 0, di = 0;
    clear_logs();
    issue(32'h0000_1000, 10, 1'b1);
    chk(cmd_ready == 1'b0, "R2 busy after take", cmd_ready, 0);
    wait_words(10);
    chk(req_a.size() == 3, "R3 request count len10", req_a.size(), 3);
    expect_cmd(32'h0000_1000, 10, 1'b1, ri, di, "incr10");
    chk(got.size() == 10, "R8 word count", got.size(), 10);
  endtask

  task automatic t_exact();
    int ri = 0, di = 0;
    clear_logs();
    issue(32'h0000_2000, 8, 1'b1);
    wait_words(8);
    chk(req_a.size() == 2, "R3 request count len8", req_a.size(), 2);
    expect_cmd(32'h0000_2000, 8, 1'b1, ri, di, "incr8");
  endtask

  task automatic t_fixed();
    int ri = 0, di = 0;
    clear_logs();
    issue(32'h0000_3000, 3, 1'b0);
    wait_words(3);
    chk(req_a.size() == 3, "R4 one request per word", req_a.size(), 3);
    expect_cmd(32'h0000_3000, 3, 1'b0, ri, di, "fixed3");
  endtask

  task automatic t_zero();
    clear_logs();
    issue(32'h0000_4000, 0, 1'b1);
    repeat (10) @(negedge clk);
    chk(req_a.size() == 0, "R10 no request", req_a.size(), 0);
    chk(cmd_ready == 1'b1, "R10 still ready", cmd_ready, 1);
    chk(got.size() == 0, "R10 no data", got.size(), 0);
  endtask

  task automatic t_gate();
    int ri = 0, di = 0, words = 0;
    logic [DW-1:0] held;
    clear_logs();
    @(negedge clk) out_ready = 1'b0;
    issue(32'h0000_5000, 20, 1'b1);
    repeat (40) @(negedge clk);
    foreach (req_b[i]) words += req_b[i];
    chk(words == DEPTH, "R7 words requested while stalled", words, DEPTH);
    chk(out_valid == 1'b1, "R11 valid while stalled", out_valid, 1);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_data == held, "R11 data held", out_data, held);
    chk(out_data == mem_f(32'h0000_5000), "R8 first word", out_data, mem_f(32'h0000_5000));
    out_ready = 1'b1;
    wait_words(20);
    expect_cmd(32'h0000_5000, 20, 1'b1, ri, di, "gate20");
  endtask

  task automatic t_b2b();
    int ri = 0, di = 0;
    clear_logs();
    stall_mode = 1'b1; rand_ready = 1'b1;
    issue(32'h0001_0000, 7, 1'b1);
    issue(32'h0002_0000, 2, 1'b0);
    issue(32'h0003_0000, 13, 1'b1);
    wait_words(22);
    stall_mode = 1'b0; rand_ready = 1'b0;
    @(negedge clk) out_ready = 1'b1;
    chk(got.size() == 22, "R8 b2b word count", got.size(), 22);
    expect_cmd(32'h0001_0000, 7, 1'b1, ri, di, "b2b_a R6");
    expect_cmd(32'h0002_0000, 2, 1'b0, ri, di, "b2b_b R2");
    expect_cmd(32'h0003_0000, 13, 1'b1, ri, di, "b2b_c");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_incr();
    t_exact();
    t_fixed();
    t_zero();
    t_gate();
    t_b2b();
    finish_run();
  end
endmodule